// File: doc/BRIEF.md
# Track Phi Merger and Pair Former

This block accepts, for each of six track buses (lettered A to F), a segment number, a 9-bit transverse-momentum word and the final wedge code assigned to that bus. For every bus it turns the wedge and segment into one linear 9-bit azimuth value, wedge × 12 + segment. It checks the wedge code and the segment for range, and marks buses that fail as invalid. It then forms all fifteen unordered pairs of the six buses. For each pair it drives two lookup addresses: one built from the two momentum words and one built from the two azimuth values.

Each 19-bit address carries a phase bit above the two 9-bit fields. The phase bit alternates on every clock, so one event is presented to the lookup memories twice: once with phase 0 and once with phase 1. A new event is taken from the inputs only on the clock edge that closes phase 1. The captured values therefore stay fixed for both phases. A per-pair valid flag tells downstream logic which addresses come from two valid buses. The lookup memories themselves are not part of this block.

Top module: `track_pair_former`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears its state. After that edge `phase_out` is 0, every `pair_ok` bit is 0 and every address bit is 0.
- R2: Out of reset, `phase_out` inverts on every rising edge. The first edge with `rst` low drives it to 1.
- R3: The inputs are captured only on a rising edge at which `phase_out` is 1. All address fields and `pair_ok` then hold for the next two cycles, while the phase is 0 and then 1. Input changes at any other edge have no effect on the outputs.
- R4: For a valid bus, the azimuth field equals wedge × 12 + segment, which ranges from 0 to 287.
- R5: A bus is valid only when its 5-bit wedge code is below 24 and its 4-bit segment is below 12. Wedge codes 24 to 30 are invalid and 31 is null. An invalid bus contributes 0 to both its momentum field and its azimuth field.
- R6: Pair slot p occupies bits [p*19+18 : p*19] of each address output and bit p of `pair_ok`. The slots are in lexicographic order: AB=0, AC=1, AD=2, AE=3, AF=4, BC=5, BD=6, BE=7, BF=8, CD=9, CE=10, CF=11, DE=12, DF=13, EF=14. Bus A is bus index 0 in the input vectors, and bus index b occupies bits [b*W+W-1 : b*W] of each input.
- R7: Within a slot, bit 18 is the current `phase_out`. Bits 17:9 hold the field of the lower-lettered bus and bits 8:0 hold the field of the higher-lettered bus. `pt_addr` uses the momentum words and `phi_addr` uses the azimuth values.
- R8: `pair_ok[p]` is 1 exactly when both buses of slot p are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_in | input | 24 | Segment number per bus, 4 bits each |
| wedge_in | input | 30 | Final wedge code per bus, 5 bits each |
| pt_in | input | 54 | Momentum/shape word per bus, 9 bits each |
| phase_out | output | 1 | Current lookup phase |
| pt_addr | output | 285 | Fifteen 19-bit momentum-pair lookup addresses |
| phi_addr | output | 285 | Fifteen 19-bit azimuth-pair lookup addresses |
| pair_ok | output | 15 | Per-pair valid flag |

## Verification
The inputs change on every cycle, so a capture edge and a phase flip fall together, and values offered during phase 0 must not reach the outputs. The bench compares each slot against its own model of the capture. That comparison shows whether the held event survives the phase change and whether only the phase bit moves. The range check and the phi arithmetic also apply in the same capture. Directed events place segment 12 and wedge 24 next to the top valid values, 11 and 23, on different buses in a single event. This shows whether pair invalidation stays confined to the slots that use the bad bus while neighbouring slots carry the maximum phi of 287.

// File: rtl/tpf_pkg.sv
package tpf_pkg;

    localparam int NBUS           = 6;
    localparam int SEG_W          = 4;
    localparam int WEDGE_W        = 5;
    localparam int FLD_W          = 9;
    localparam int SEGS_PER_WEDGE = 12;
    localparam int NUM_WEDGES     = 24;
    localparam int NPAIR          = NBUS * (NBUS - 1) / 2;
    localparam int ADDR_W         = 2 * FLD_W + 1;

    typedef struct packed {
        logic             ok;
        logic [FLD_W-1:0] pt;
        logic [FLD_W-1:0] phi;
    } trk_t;

    function automatic logic code_ok(input logic [WEDGE_W-1:0] w,
                                     input logic [SEG_W-1:0]   s);
        return (int'(w) < NUM_WEDGES) && (int'(s) < SEGS_PER_WEDGE);
    endfunction

    function automatic logic [FLD_W-1:0] lin_phi(input logic [WEDGE_W-1:0] w,
                                                 input logic [SEG_W-1:0]   s);
        int v;
        v = int'(w) * SEGS_PER_WEDGE + int'(s);
        return FLD_W'(v);
    endfunction

    // Lower-lettered member of pair slot p, lexicographic slot order.
    function automatic int pair_first(input int p);
        int k;
        int r;
        k = 0;
        r = 0;
        for (int i = 0; i < NBUS; i++)
            for (int j = i + 1; j < NBUS; j++) begin
                if (k == p) r = i;
                k++;
            end
        return r;
    endfunction

    // Higher-lettered member of pair slot p.
    function automatic int pair_second(input int p);
        int k;
        int r;
        k = 0;
        r = 0;
        for (int i = 0; i < NBUS; i++)
            for (int j = i + 1; j < NBUS; j++) begin
                if (k == p) r = j;
                k++;
            end
        return r;
    endfunction

endpackage

// File: rtl/tpf_bus_conv.sv
module tpf_bus_conv
    import tpf_pkg::*;
(
    input  logic [SEG_W-1:0]   seg_i,
    input  logic [WEDGE_W-1:0] wedge_i,
    input  logic [FLD_W-1:0]   pt_i,
    output trk_t               trk_o
);
    logic ok;

    always_comb begin
        ok        = code_ok(wedge_i, seg_i);
        trk_o.ok  = ok;
        trk_o.pt  = ok ? pt_i : '0;
        trk_o.phi = ok ? lin_phi(wedge_i, seg_i) : '0;
    end
endmodule

// File: rtl/tpf_event_reg.sv
module tpf_event_reg
    import tpf_pkg::*;
#(
    parameter int N = NBUS
) (
    input  logic               clk,
    input  logic               rst,
    input  trk_t [N-1:0]       nxt_i,
    output trk_t [N-1:0]       cur_o,
    output logic               phase_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_o <= 1'b0;
            cur_o   <= '0;
        end else begin
            phase_o <= ~phase_o;
            if (phase_o) cur_o <= nxt_i;
        end
    end
endmodule

// File: rtl/tpf_pair_gen.sv
module tpf_pair_gen
    import tpf_pkg::*;
(
    input  trk_t              lo_i,
    input  trk_t              hi_i,
    input  logic              phase_i,
    output logic [ADDR_W-1:0] pt_addr_o,
    output logic [ADDR_W-1:0] phi_addr_o,
    output logic              ok_o
);
    always_comb begin
        pt_addr_o  = {phase_i, lo_i.pt,  hi_i.pt};
        phi_addr_o = {phase_i, lo_i.phi, hi_i.phi};
        ok_o       = lo_i.ok & hi_i.ok;
    end
endmodule

// File: rtl/track_pair_former.sv
module track_pair_former
    import tpf_pkg::*;
#(
    parameter int NB  = NBUS,
    parameter int SW  = SEG_W,
    parameter int WW  = WEDGE_W,
    parameter int FW  = FLD_W,
    localparam int NP = NB * (NB - 1) / 2,
    localparam int AW = 2 * FW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NB*SW-1:0] seg_in,
    input  logic [NB*WW-1:0] wedge_in,
    input  logic [NB*FW-1:0] pt_in,
    output logic             phase_out,
    output logic [NP*AW-1:0] pt_addr,
    output logic [NP*AW-1:0] phi_addr,
    output logic [NP-1:0]    pair_ok
);
    trk_t [NB-1:0] trk_nxt;
    trk_t [NB-1:0] trk_cur;
    logic          phase;

    for (genvar b = 0; b < NB; b++) begin : g_bus
        tpf_bus_conv u_conv (
            .seg_i   (seg_in[b*SW +: SW]),
            .wedge_i (wedge_in[b*WW +: WW]),
            .pt_i    (pt_in[b*FW +: FW]),
            .trk_o   (trk_nxt[b])
        );
    end

    tpf_event_reg #(.N(NB)) u_evt (
        .clk     (clk),
        .rst     (rst),
        .nxt_i   (trk_nxt),
        .cur_o   (trk_cur),
        .phase_o (phase)
    );

    for (genvar p = 0; p < NP; p++) begin : g_pair
        localparam int LO = pair_first(p);
        localparam int HI = pair_second(p);
        tpf_pair_gen u_pair (
            .lo_i       (trk_cur[LO]),
            .hi_i       (trk_cur[HI]),
            .phase_i    (phase),
            .pt_addr_o  (pt_addr[p*AW +: AW]),
            .phi_addr_o (phi_addr[p*AW +: AW]),
            .ok_o       (pair_ok[p])
        );
    end

    assign phase_out = phase;
endmodule

// File: rtl/tpf_checker.sv
module tpf_checker #(
    parameter int NP = 15,
    parameter int FW = 9,
    localparam int AW = 2 * FW + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             phase_out,
    input logic [NP*AW-1:0] pt_addr,
    input logic [NP*AW-1:0] phi_addr,
    input logic [NP-1:0]    pair_ok
);
    function automatic logic [NP*AW-1:0] field_mask();
        logic [NP*AW-1:0] m;
        m = '1;
        for (int p = 0; p < NP; p++) m[p*AW + AW - 1] = 1'b0;
        return m;
    endfunction

    localparam logic [NP*AW-1:0] FMASK = field_mask();

    logic [NP*AW-1:0] pt_fields;
    logic [NP*AW-1:0] phi_fields;
    assign pt_fields  = pt_addr & FMASK;
    assign phi_fields = phi_addr & FMASK;

    // R2: phase alternates every cycle out of reset
    assert_phase_flip_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> phase_out != $past(phase_out));

    // R3: fields and flags do not move from phase 0 to phase 1
    assert_hold_event_R3: assert property (@(posedge clk) disable iff (rst)
        !phase_out |=> ($stable(pt_fields) && $stable(phi_fields) && $stable(pair_ok)));

    for (genvar p = 0; p < NP; p++) begin : g_slot
        // R7: each slot's top bit follows the phase register
        assert_slot_phase_R7: assert property (@(posedge clk) disable iff (rst)
            pt_addr[p*AW + AW - 1] == phase_out && phi_addr[p*AW + AW - 1] == phase_out);
        // R4: a valid pair carries phi values within the linear range
        assert_phi_range_R4: assert property (@(posedge clk) disable iff (rst)
            pair_ok[p] |-> (phi_addr[p*AW + FW +: FW] <= 9'd287 && phi_addr[p*AW +: FW] <= 9'd287));
    end

    // R8: slots AB and CD valid means A,B,C,D valid, so AC, AD, BC, BD are valid
    assert_pair_consistent_R8: assert property (@(posedge clk) disable iff (rst)
        (pair_ok[0] && pair_ok[9]) |-> (pair_ok[1] && pair_ok[2] && pair_ok[5] && pair_ok[6]));
endmodule

bind track_pair_former tpf_checker #(.NP(NP), .FW(FW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .phase_out (phase_out),
    .pt_addr   (pt_addr),
    .phi_addr  (phi_addr),
    .pair_ok   (pair_ok)
);

// File: tb/track_pair_former_tb.sv
module track_pair_former_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 6;
    localparam int NP = 15;
    localparam int AW = 19;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] seg_v [NB];
    logic [4:0] wed_v [NB];
    logic [8:0] pt_v  [NB];
    logic [NB*4-1:0] seg_in;
    logic [NB*5-1:0] wedge_in;
    logic [NB*9-1:0] pt_in;
    logic phase_out;
    logic [NP*AW-1:0] pt_addr;
    logic [NP*AW-1:0] phi_addr;
    logic [NP-1:0] pair_ok;

    int total = 0;
    int bad = 0;

    // bench model of captured event
    logic [3:0] m_seg [NB];
    logic [4:0] m_wed [NB];
    logic [8:0] m_pt  [NB];
    logic       m_phase;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            seg_in[b*4 +: 4]   = seg_v[b];
            wedge_in[b*5 +: 5] = wed_v[b];
            pt_in[b*9 +: 9]    = pt_v[b];
        end
    end

    track_pair_former dut_i (
        .clk(clk), .rst(rst), .seg_in(seg_in), .wedge_in(wedge_in), .pt_in(pt_in),
        .phase_out(phase_out), .pt_addr(pt_addr), .phi_addr(phi_addr), .pair_ok(pair_ok)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_phase <= 1'b0;
            for (int b = 0; b < NB; b++) begin
                m_seg[b] <= 4'd0; m_wed[b] <= 5'd31; m_pt[b] <= 9'd0;
            end
        end else begin
            m_phase <= ~m_phase;
            if (m_phase) begin
                for (int b = 0; b < NB; b++) begin
                    m_seg[b] <= seg_v[b]; m_wed[b] <= wed_v[b]; m_pt[b] <= pt_v[b];
                end
            end
        end
    end

    function automatic bit bus_ok(input int b);
        return (m_wed[b] < 5'd24) && (m_seg[b] < 4'd12);
    endfunction
    function automatic logic [8:0] bus_phi(input int b);
        int v;
        v = bus_ok(b) ? (int'(m_wed[b]) * 12 + int'(m_seg[b])) : 0;
        return v[8:0];
    endfunction
    function automatic logic [8:0] bus_pt(input int b);
        return bus_ok(b) ? m_pt[b] : 9'd0;
    endfunction

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // R2 phase, R4/R5 field values, R6 slot order, R7 layout, R8 flags
    task automatic check_all();
        int p;
        chk_eq("R2 phase", 32'(phase_out), 32'(m_phase));
        p = 0;
        for (int i = 0; i < NB; i++) begin
            for (int j = i + 1; j < NB; j++) begin
                chk_eq($sformatf("R7/R6/R5 pt slot %0d", p),
                       32'(pt_addr[p*AW +: AW]), 32'({m_phase, bus_pt(i), bus_pt(j)}));
                chk_eq($sformatf("R4/R6/R5 phi slot %0d", p),
                       32'(phi_addr[p*AW +: AW]), 32'({m_phase, bus_phi(i), bus_phi(j)}));
                chk_eq($sformatf("R8 ok slot %0d", p),
                       32'(pair_ok[p]), 32'(bus_ok(i) && bus_ok(j)));
                p++;
            end
        end
    endtask

    task automatic check_reset();
        chk_eq("R1 phase", 32'(phase_out), 32'd0);
        chk_eq("R1 ok", 32'(pair_ok), 32'd0);
        chk_eq("R1 pt", 32'(|pt_addr), 32'd0);
        chk_eq("R1 phi", 32'(|phi_addr), 32'd0);
    endtask

    task automatic rand_inputs();
        for (int b = 0; b < NB; b++) begin
            wed_v[b] = ($urandom_range(0, 9) < 7) ? 5'($urandom_range(0, 23)) : 5'($urandom_range(24, 31));
            seg_v[b] = ($urandom_range(0, 9) < 8) ? 4'($urandom_range(0, 11)) : 4'($urandom_range(12, 15));
            pt_v[b]  = 9'($urandom);
        end
    endtask

    // one cycle: check at negedge, then present next stimulus
    task automatic step();
        @(negedge clk);
        check_all();
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int b = 0; b < NB; b++) begin
            seg_v[b] = 4'd5; wed_v[b] = 5'd3; pt_v[b] = 9'h1AB;
        end
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_reset();                                  // R1
        rst = 1'b0;
        step(); step();
        // directed: top valid values on every bus (phi 287)
        for (int b = 0; b < NB; b++) begin
            seg_v[b] = 4'd11; wed_v[b] = 5'd23; pt_v[b] = 9'(b * 37 + 1);
        end
        repeat (4) step();
        // directed: boundaries side by side (R5): seg 12, wedge 24, null 31
        seg_v[1] = 4'd12; wed_v[3] = 5'd24; wed_v[5] = 5'd31;
        repeat (4) step();
        // directed: all null
        for (int b = 0; b < NB; b++) wed_v[b] = 5'd31;
        repeat (4) step();
        // random, inputs changing every cycle (R3: phase-0 values ignored)
        for (int n = 0; n < 500; n++) begin
            rand_inputs();
            step();
        end
        // mid-run reset (R1)
        rst = 1'b1;
        @(negedge clk);
        check_reset();
        rst = 1'b0;
        for (int n = 0; n < 100; n++) begin
            rand_inputs();
            step();
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule